// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line. The frame format is chosen per frame at run time: the number of data bits, whether a parity bit is added and of which sense, and the length of the stop period. All bit timing comes from an oversample enable that pulses once per sixteenth of a bit period. Because the block counts these enables rather than whole bit periods, it can time a stop period of one and a half bits.

A host places a word and a format on the inputs and pulses the start strobe while the block is idle. The block captures both, raises its busy flag and sends the frame. It then gives a single-cycle completion pulse and is ready for the next word in that same cycle. The enable generator, any queueing of words and any flow control are outside this block.

Top module: `ser_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, the serial line is 1, busy is 0 and done is 0.
- R2: A start strobe seen while idle is accepted on that clock edge. From the next cycle busy is 1 and the line is 0 for exactly 16 oversample enables (the start bit).
- R3: Data bits follow the start bit with the least significant bit first, and each bit holds the line for 16 enables.
- R4: The word length code selects the number of data bits: code 0 gives 6, code 1 gives 7, and codes 2 and 3 give 8. Input bits above the selected length are never sent.
- R5: With parity enabled, one 16-enable parity bit follows the last data bit. With the odd-select input at 0 (even), the sent data bits plus parity hold an even number of ones. With it at 1 (odd), they hold an odd number. With parity disabled, no parity bit is sent.
- R6: The stop code selects a stop period with the line at 1. Code 0 lasts 16 enables, code 1 lasts 24 enables, and codes 2 and 3 last 32 enables.
- R7: A start strobe is ignored while busy is 1. Data and format are captured at acceptance, so input changes during a frame do not alter it.
- R8: On the clock edge that counts the last enable of the stop period, done goes to 1 for exactly one cycle and busy goes to 0. A start strobe in that cycle is accepted.
- R9: Timing advances only on cycles where the oversample enable is 1. The line holds its value through any run of cycles without an enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Oversample enable, 16 per bit period |
| start | input | 1 | Start strobe; a new frame is accepted when idle |
| din | input | DATA_W | Word to send, bit 0 first |
| cfg_wlen | input | 2 | Word length code (0: 6 bits, 1: 7 bits, 2 or 3: 8 bits) |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfg_stop | input | 2 | Stop code (0: 1 bit, 1: 1.5 bits, 2 or 3: 2 bits) |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Single-cycle pulse at the end of a frame |

## Verification
The assertions assume that os_tick is a plain enable, sampled only at clock edges. They also assume that start and the format inputs matter only in the cycle a frame is accepted. Nothing is assumed about their values while busy is 1.

The stimulus violates none of this but tests its edges:
- It drives the enable in several cadences, including one with idle cycles between enables.
- It scrambles the data and format inputs right after every acceptance.
- It pulses start in the middle of each frame.
- It begins each new frame in the very cycle done is seen.

The bench covers every word length, parity and stop code combination, with several data words including all-zero and all-one patterns.

// File: rtl/sertx_pkg.sv
// Package: shared phase encoding for the serial transmitter.
// Assumes nothing; holds types only.
package sertx_pkg;

    // Frame phases, in the order the line visits them.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } tx_phase_e;

endpackage

// File: rtl/tx_bit_timer.sv
// Module: tick counter that marks the last oversample enable of a bit or stop period.
// Assumes limit only changes in the cycle the counter wraps or while clear is high.
module tx_bit_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             at_last
);

    logic [CNT_W-1:0] cnt_q;

    // Count enables; wrap to zero at the limit; hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == limit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Flag the enable that closes the current period.
    always_comb begin
        at_last = tick && (cnt_q == limit);
    end

    // R9: without an enable the count does not move
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt_q));

    // R6: count never passes the period limit
    a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

endmodule

// File: rtl/tx_parity.sv
// Module: parity of the low word-length bits of a word.
// Assumes the word length code follows the block's mapping (0: W-2, 1: W-1, else W bits).
module tx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        wlen,
    input  logic              odd,
    output logic              par
);

    localparam int MIN_W = DATA_W - 2;

    int unsigned nbits;
    logic        acc;

    // Decode the word length code to a bit count.
    always_comb begin
        case (wlen)
            2'd0:    nbits = MIN_W;
            2'd1:    nbits = MIN_W + 1;
            default: nbits = DATA_W;
        endcase
    end

    // XOR only the bits that will be sent, then apply the sense.
    always_comb begin
        acc = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) begin
                acc = acc ^ data[i];
            end
        end
        par = acc ^ odd;
    end

endmodule

// File: rtl/tx_frame_ctrl.sv
// Module: frame sequencer. Captures word and format at acceptance, walks the
// start, data, parity and stop phases, and drives the line, busy and done.
// Assumes at_last comes from a timer cleared while idle and loaded with period_lim.
module tx_frame_ctrl
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_stop_half,
    input  logic              cfg_stop_two,
    input  logic              par_bit,
    input  logic              at_last,
    output logic              tmr_clear,
    output logic [CNT_W-1:0]  period_lim,
    output logic              txd,
    output logic              busy,
    output logic              done
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LIM_BIT  = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(OVS + OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * OVS - 1);

    tx_phase_e         phase_q;
    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  bitidx_q;
    logic [IDX_W-1:0]  lastidx_q;
    logic              par_en_q;
    logic              par_q;
    logic [1:0]        stop_sel_q;
    logic              done_q;
    logic [IDX_W-1:0]  lastidx_d;

    // Map the word length code to the index of the last data bit.
    always_comb begin
        case (cfg_wlen)
            2'd0:    lastidx_d = IDX_W'(DATA_W - 3);
            2'd1:    lastidx_d = IDX_W'(DATA_W - 2);
            default: lastidx_d = IDX_W'(DATA_W - 1);
        endcase
    end

    // Phase sequencing, capture at acceptance, and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            shreg_q    <= '0;
            bitidx_q   <= '0;
            lastidx_q  <= '0;
            par_en_q   <= 1'b0;
            par_q      <= 1'b0;
            stop_sel_q <= 2'd0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        shreg_q    <= din;
                        lastidx_q  <= lastidx_d;
                        par_en_q   <= cfg_par_en;
                        par_q      <= par_bit;
                        stop_sel_q <= {cfg_stop_two, cfg_stop_half};
                        bitidx_q   <= '0;
                        phase_q    <= PH_START;
                    end
                end
                PH_START: begin
                    if (at_last) begin
                        phase_q <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (at_last) begin
                        shreg_q <= shreg_q >> 1;
                        if (bitidx_q == lastidx_q) begin
                            phase_q <= par_en_q ? PH_PAR : PH_STOP;
                        end else begin
                            bitidx_q <= bitidx_q + 1'b1;
                        end
                    end
                end
                PH_PAR: begin
                    if (at_last) begin
                        phase_q <= PH_STOP;
                    end
                end
                PH_STOP: begin
                    if (at_last) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Period length for the timer: one bit, or the chosen stop length.
    always_comb begin
        period_lim = LIM_BIT;
        if (phase_q == PH_STOP) begin
            if (stop_sel_q[1]) begin
                period_lim = LIM_TWO;
            end else if (stop_sel_q[0]) begin
                period_lim = LIM_HALF;
            end
        end
    end

    // Line level per phase; the timer rests while idle.
    always_comb begin
        case (phase_q)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = shreg_q[0];
            PH_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
        tmr_clear = (phase_q == PH_IDLE);
        busy      = (phase_q != PH_IDLE);
        done      = done_q;
    end

    // R1: an idle block holds the line high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2: the first busy cycle is the start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R7: captured format stays fixed for the whole frame
    a_r7_format_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(stop_sel_q) && $stable(par_en_q)
                                    && $stable(par_q) && $stable(lastidx_q)));

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done closes a frame that was in progress
    a_r8_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

// File: rtl/ser_frame_tx.sv
// Module: top of the configurable asynchronous serial transmitter.
// Assumes os_tick pulses OVS times per bit period and is synchronous to clk.
module ser_frame_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_stop,
    output logic              txd,
    output logic              busy,
    output logic              done
);

    localparam int CNT_W = $clog2(2 * OVS);

    logic             par_bit;
    logic             at_last;
    logic             tmr_clear;
    logic [CNT_W-1:0] period_lim;

    tx_parity #(.DATA_W(DATA_W)) u_par (
        .data (din),
        .wlen (cfg_wlen),
        .odd  (cfg_par_odd),
        .par  (par_bit)
    );

    tx_bit_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .tick    (os_tick),
        .limit   (period_lim),
        .at_last (at_last)
    );

    tx_frame_ctrl #(.DATA_W(DATA_W), .OVS(OVS), .CNT_W(CNT_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .din           (din),
        .cfg_wlen      (cfg_wlen),
        .cfg_par_en    (cfg_par_en),
        .cfg_stop_half (cfg_stop[0]),
        .cfg_stop_two  (cfg_stop[1]),
        .par_bit       (par_bit),
        .at_last       (at_last),
        .tmr_clear     (tmr_clear),
        .period_lim    (period_lim),
        .txd           (txd),
        .busy          (busy),
        .done          (done)
    );

endmodule

// File: tb/sim_ser_frame_tx.sv
module sim_ser_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       start = 1'b0;
    logic [7:0] din = 8'h00;
    logic [1:0] cfg_wlen = 2'd0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic       txd, busy, done;

    int checks = 0;
    int errors = 0;
    int frame_no = 0;

    always #4 clk = ~clk;

    ser_frame_tx #(.DATA_W(8), .OVS(16)) u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .start(start), .din(din),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop(cfg_stop), .txd(txd), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Expected line level after k enables of a frame (start, data, parity, stop).
    function automatic logic exp_level(input int k, input logic [7:0] d, input int w,
                                       input logic pe, input logic pb);
        int idx = k / 16;
        if (idx == 0) return 1'b0;
        if (idx <= w) return d[idx-1];
        if (pe && idx == w + 1) return pb;
        return 1'b1;
    endfunction

    // Send one frame; called and returns at a falling edge.
    task automatic run_frame(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                             input logic po, input logic [1:0] st);
        int w     = (wl == 2'd0) ? 6 : (wl == 2'd1) ? 7 : 8;
        int stt   = (st == 2'd0) ? 16 : (st == 2'd1) ? 24 : 32;
        int total = 16 * (1 + w + (pe ? 1 : 0)) + stt;
        int per   = (frame_no % 4 == 0) ? 3 : (frame_no % 4 == 1) ? 2 : 1;
        int k = 0, cyc = 0, bad = 0, bad_k = -1, bad_act = 0, bad_exp = 0;
        int ones = 0;
        logic pb;
        for (int i = 0; i < w; i++) ones += d[i];
        pb = ((ones % 2) != 0) ^ po;   // R5: makes data+parity even (po=0) or odd (po=1)
        din = d; cfg_wlen = wl; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = st;
        start = 1'b1; os_tick = 1'b0;
        @(negedge clk);
        start = 1'b0;
        // R7: scramble inputs after acceptance
        din = ~d; cfg_wlen = ~wl; cfg_par_en = ~pe; cfg_par_odd = ~po; cfg_stop = ~st;
        while (k < total && cyc < 5000) begin
            if (!(busy === 1'b1 && done === 1'b0 && txd === exp_level(k, d, w, pe, pb))) begin
                bad++;
                if (bad_k < 0) begin
                    bad_k = k; bad_act = {busy, done, txd};
                    bad_exp = {2'b10, exp_level(k, d, w, pe, pb)};
                end
            end
            start   = (k == 20);      // R7: strobe while busy must be ignored
            os_tick = ((cyc % per) == 0);
            if (os_tick) k++;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0; os_tick = 1'b0;
        // R2 R3 R4 R5 R6 R7 R9: every cycle of the frame matched the model
        check(bad == 0, "R3/R4/R5", $sformatf("frame %0d wave {busy,done,txd} at tick %0d",
              frame_no, bad_k), bad_act, bad_exp);
        // R6 R8: done and idle exactly after the stop period
        check(done === 1'b1 && busy === 1'b0 && txd === 1'b1, "R8",
              $sformatf("frame %0d end {busy,done,txd}", frame_no),
              {busy, done, txd}, 3'b011);
        frame_no++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(txd === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "in reset {busy,done,txd}",
              {busy, done, txd}, 3'b001);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1, R9: idle with enables running and no strobe
        os_tick = 1'b1;
        repeat (10) @(negedge clk);
        os_tick = 1'b0;
        check(txd === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "idle {busy,done,txd}",
              {busy, done, txd}, 3'b001);
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int st = 0; st < 4; st++) begin
                    for (int i = 0; i < 4; i++) begin
                        logic [7:0] d;
                        d = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF :
                            8'((wl * 53 + pm * 29 + st * 17 + i * 101) ^ 8'hA5);
                        // R8: frames start back to back in the done cycle
                        run_frame(d, 2'(wl), pm != 0, pm == 2, 2'(st));
                    end
                end
            end
        end
        @(negedge clk);
        // R8: done lasted one cycle
        check(done === 1'b0 && busy === 1'b0 && txd === 1'b1, "R8", "after last frame {busy,done,txd}",
              {busy, done, txd}, 3'b001);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule